// File: doc/BRIEF.md
# Multi-Timer Unit with Shared Prescaler

This block is the shared front end of a group of timer channels. It holds one 16-bit prescaler that counts down on every clock, and it emits a one-cycle tick whenever the count reaches zero. That tick is the time base for every channel. The block decodes a simple 32-bit word-addressed register bus. The low window holds the prescaler count, the prescaler reload value and a read-only capability word. Each channel gets its own 16-byte window above the low window.

The channel logic itself sits outside this block. For a channel window, the unit drives that channel's write strobe, the word index inside the window and the write data, and it returns that channel's read data on the bus. The per-channel interrupt lines pass straight through to the outputs, one line per channel. Reads from unmapped locations return zero, and writes to them change nothing.

Top module: `tmr_unit`

## Requirements
- R1: The unit window is byte offsets 0x00..0x0F: word 0x00 is the prescaler count, 0x04 the prescaler reload, 0x08 the capability word, and 0x0C reads zero and ignores writes. The bus carries word address bits [7:2] only.
- R2: Prescaler count and reload are 16 bits wide. Writes keep write-data bits [15:0] and drop the rest, and reads return the value zero-extended to 32 bits.
- R3: The tick output is high in exactly those cycles where the prescaler count is zero. At each clock edge a zero count loads the reload value and a nonzero count decrements by one. The tick period is therefore reload+1 clocks, and a reload of zero ticks on every clock.
- R4: A write to the prescaler count takes effect at the next edge and overrides both the decrement and the reload.
- R5: The capability word is read-only. Bits [2:0] hold the channel count modulo 8, bits [7:3] the base interrupt number, bit 8 is 1 (separate interrupts) and bit 9 is 1 (freeze-disable). All other bits are 0. Writes to it have no effect.
- R6: Channel n (0-based) sits at byte offset 0x10*(n+1). A write to word offset +0x0, +0x4 or +0x8 raises only chWrStb[n] for that cycle, with chWordSel equal to 0, 1 or 2 and chWrData equal to the bus write data.
- R7: A read of word offset +0x0, +0x4 or +0x8 in channel n's window returns slice n of chRdData, with chWordSel set to the word index.
- R8: Word +0xC of a channel window, and every window of a channel number at or above NUM_CH, read zero and raise no write strobe.
- R9: After reset the prescaler count and reload are zero, so the tick is high from the first cycle.
- R10: irqOut[n] follows chIrqIn[n] for every channel.
- R11: With busWe low, no write strobe is raised and no unit register changes apart from the prescaler counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Word address, byte address bits [7:2] |
| busWe | input | 1 | Write enable for the current word access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word |
| tick | output | 1 | Prescaler underflow strobe to all channels |
| chWrStb | output | NUM_CH | One write strobe per channel |
| chWordSel | output | 2 | Word index inside the addressed channel window |
| chWrData | output | 32 | Write data forwarded to the channels |
| chRdData | input | 32*NUM_CH | Read data from each channel, channel n in bits [32n+31:32n] |
| chIrqIn | input | NUM_CH | Interrupt request from each channel |
| irqOut | output | NUM_CH | Per-channel interrupt lines |

## Verification
On every cycle the assertions check the prescaler's decrement, reload and write-override steps. They also check that at most one write strobe is raised, that strobes stay off with busWe low or outside the mapped windows, that unmapped windows read zero and that the capability word holds its fixed value. Only the bench's scenarios can show the tick period for several reload values, the correct routing of each channel's read data with its word index, and truncation of wide writes. The bench's reference model tracks the prescaler and the whole address map and compares the tick, read data, strobes and interrupts on every clock.

// File: rtl/tmr_unit_pkg.sv
package tmr_unit_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_PVAL,
    RD_PRLD,
    RD_CAPS,
    RD_CHAN
  } rdSrc_e;

  // strobes from the decoder into the datapath
  typedef struct packed {
    logic   valWe;
    logic   rldWe;
    rdSrc_e rdSrc;
    logic [2:0] chIdx;
  } ctrlStb_t;

endpackage

// File: rtl/tmr_unit_ctrl.sv
module tmr_unit_ctrl
  import tmr_unit_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:2]        busAddr,
  input  logic              busWe,
  output ctrlStb_t          stb,
  output logic [NUM_CH-1:0] chWe,
  output logic [1:0]        wordSel
);

  localparam logic [3:0] LAST_WIN = 4'(NUM_CH);

  logic [3:0] winIdx;
  logic [1:0] wordIdx;

  assign winIdx  = busAddr[7:4];
  assign wordIdx = busAddr[3:2];
  assign wordSel = wordIdx;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_win
    assign chWe[i] = busWe && (winIdx == 4'(i + 1)) && (wordIdx != 2'd3);
  end

  always_comb begin
    stb       = '0;
    stb.rdSrc = RD_ZERO;
    stb.chIdx = 3'(winIdx - 4'd1);
    if (winIdx == 4'd0) begin
      case (wordIdx)
        2'd0: begin stb.rdSrc = RD_PVAL; stb.valWe = busWe; end
        2'd1: begin stb.rdSrc = RD_PRLD; stb.rldWe = busWe; end
        2'd2: stb.rdSrc = RD_CAPS;
        default: stb.rdSrc = RD_ZERO;
      endcase
    end else if ((winIdx <= LAST_WIN) && (wordIdx != 2'd3)) begin
      stb.rdSrc = RD_CHAN;
    end
  end

  // R6: never more than one register written per access
  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chWe, stb.valWe, stb.rldWe}));

  // R11: no strobes without a write
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> (chWe == '0) && !stb.valWe && !stb.rldWe);

  // R8: windows past the channel count raise nothing
  assert_phantom_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    (winIdx > LAST_WIN) |-> (chWe == '0));

endmodule

// File: rtl/tmr_unit_dpath.sv
module tmr_unit_dpath
  import tmr_unit_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8,
  parameter int PRE_W    = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStb_t              stb,
  input  logic [PRE_W-1:0]      wdata,
  input  logic [NUM_CH*32-1:0]  chRdData,
  output logic [31:0]           rdata,
  output logic                  tick
);

  localparam logic [31:0] CAPS_WORD =
    {22'd0, 1'b1, 1'b1, 5'(IRQ_BASE), 3'(NUM_CH)};

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] rld;
  logic [31:0]      chMux;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.valWe) begin
      cnt <= wdata;
    end else if (tick) begin
      cnt <= rld;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rld <= '0;
    end else if (stb.rldWe) begin
      rld <= wdata;
    end
  end

  always_comb begin
    chMux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (stb.chIdx == 3'(i)) chMux = chRdData[i*32 +: 32];
    end
  end

  always_comb begin
    case (stb.rdSrc)
      RD_PVAL: rdata = 32'(cnt);
      RD_PRLD: rdata = 32'(rld);
      RD_CAPS: rdata = CAPS_WORD;
      RD_CHAN: rdata = chMux;
      default: rdata = '0;
    endcase
  end

  // R3: underflow reloads
  assert_underflow_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !stb.valWe) |=> (cnt == $past(rld)));

  // R3: nonzero count steps down by one
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !stb.valWe) |=> (cnt == $past(cnt) - 1'b1));

  // R4: a written count wins over reload and decrement
  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.valWe |=> (cnt == $past(wdata)));

  // R11: reload only changes on its own write
  assert_reload_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rldWe |=> $stable(rld));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_unit_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8,
  parameter int PRE_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:2]           busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 tick,
  output logic [NUM_CH-1:0]    chWrStb,
  output logic [1:0]           chWordSel,
  output logic [31:0]          chWrData,
  input  logic [NUM_CH*32-1:0] chRdData,
  input  logic [NUM_CH-1:0]    chIrqIn,
  output logic [NUM_CH-1:0]    irqOut
);

  localparam logic [3:0]  TOP_WIN  = 4'(NUM_CH);
  localparam logic [31:0] CAPS_REF =
    32'((1 << 9) | (1 << 8) | ((IRQ_BASE % 32) << 3) | (NUM_CH % 8));

  ctrlStb_t stb;

  tmr_unit_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb),
    .chWe    (chWrStb),
    .wordSel (chWordSel)
  );

  tmr_unit_dpath #(
    .NUM_CH   (NUM_CH),
    .IRQ_BASE (IRQ_BASE),
    .PRE_W    (PRE_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (busWdata[PRE_W-1:0]),
    .chRdData (chRdData),
    .rdata    (busRdata),
    .tick     (tick)
  );

  assign chWrData = busWdata;
  assign irqOut   = chIrqIn;

  // R8: windows beyond the channel count read zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[7:4] > TOP_WIN) |-> (busRdata == 32'd0));

  // R5: capability word is fixed
  assert_caps_fixed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 6'h02) |-> (busRdata == CAPS_REF));

endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;

  localparam int NCH  = 3;
  localparam int IRQB = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:2]        busAddr = '0;
  logic              busWe = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              tick;
  logic [NCH-1:0]    chWrStb;
  logic [1:0]        chWordSel;
  logic [31:0]       chWrData;
  logic [NCH*32-1:0] chRdData;
  logic [NCH-1:0]    chIrqIn = '0;
  logic [NCH-1:0]    irqOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  int mCnt = 0;
  int mRld = 0;

  always #10 clk = ~clk;

  tmr_unit #(.NUM_CH(NCH), .IRQ_BASE(IRQB)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tick(tick),
    .chWrStb(chWrStb), .chWordSel(chWordSel), .chWrData(chWrData),
    .chRdData(chRdData), .chIrqIn(chIrqIn), .irqOut(irqOut)
  );

  // channel stand-ins: data tagged with channel and word index
  always_comb begin
    for (int i = 0; i < NCH; i++)
      chRdData[i*32 +: 32] = 32'hC0DE_0000 | 32'(i << 8) | 32'(chWordSel);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRd(input int a);
    int win = a >> 4;
    int w   = (a >> 2) & 3;
    if (win == 0) begin
      case (w)
        0: return 32'(mCnt);
        1: return 32'(mRld);
        2: return 32'(NCH + IRQB * 8 + 256 + 512);
        default: return 32'd0;
      endcase
    end
    if (win <= NCH && w < 3) return 32'hC0DE_0000 | 32'((win - 1) << 8) | 32'(w);
    return 32'd0;
  endfunction

  function automatic string rdTag(input int a);
    int win = a >> 4;
    int w   = (a >> 2) & 3;
    if (win == 0) return (w == 2) ? "R5" : (w == 3) ? "R1" : "R2";
    if (win <= NCH && w < 3) return "R7";
    return "R8";
  endfunction

  task automatic step(input bit we, input int a, input logic [31:0] d);
    int win = a >> 4;
    int w   = (a >> 2) & 3;
    bit inWin = (win >= 1) && (win <= NCH) && (w < 3);
    logic [NCH-1:0] expStb = '0;
    busWe = we; busAddr = 6'(a >> 2); busWdata = d;
    #1;
    if (we && inWin) expStb[win-1] = 1'b1;
    chk(tick === (mCnt == 0), "R3", 32'(tick), 32'(mCnt == 0));
    chk(busRdata === expRd(a), rdTag(a), busRdata, expRd(a));
    chk(chWrStb === expStb, !we ? "R11" : inWin ? "R6" : "R8",
        32'(chWrStb), 32'(expStb));
    if (inWin) chk(chWordSel === 2'(w), "R6", 32'(chWordSel), 32'(w));
    if (we && inWin) chk(chWrData === d, "R6", chWrData, d);
    chk(irqOut === chIrqIn, "R10", 32'(irqOut), 32'(chIrqIn));
    @(posedge clk);
    if (we && win == 0 && w == 0) mCnt = int'(d & 32'hFFFF);
    else if (mCnt == 0) mCnt = mRld;
    else mCnt = mCnt - 1;
    if (we && win == 0 && w == 1) mRld = int'(d & 32'hFFFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: count and reload at zero right after reset, tick high
    step(0, 'h00, 0);
    step(0, 'h04, 0);
    // R1 R7 R8: full read sweep
    for (int a = 0; a < 256; a += 4) step(0, a, 0);
    // R5: capability word ignores writes
    step(1, 'h08, 32'hFFFF_FFFF);
    step(0, 'h08, 0);
    step(1, 'h0C, 32'h1234_5678);
    step(0, 'h0C, 0);
    // R2: wide write truncated
    step(1, 'h04, 32'hABCD_0003);
    step(0, 'h04, 0);
    // R3: period of four
    for (int k = 0; k < 14; k++) step(0, 'h00, 0);
    // R3: reload zero ticks every clock
    step(1, 'h04, 0);
    for (int k = 0; k < 6; k++) step(0, 'h00, 0);
    // R4: count write overrides
    step(1, 'h04, 7);
    step(1, 'h00, 32'hFFFF_0005);
    for (int k = 0; k < 12; k++) step(0, 'h00, 0);
    while (mCnt != 0) step(0, 'h00, 0);
    step(1, 'h00, 2);
    for (int k = 0; k < 6; k++) step(0, 'h00, 0);
    // R6 R8: write sweep over channel windows
    for (int a = 16; a < 256; a += 4) begin
      chIrqIn = 3'(a >> 2);
      step(1, a, 32'h5A00_0000 | 32'(a));
    end
    // R10 R11: idle bus, interrupts toggling
    for (int k = 0; k < 16; k++) begin
      chIrqIn = 3'(k * 5);
      step(0, (k * 36) & 8'hFC, 32'hFFFF_FFFF);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule